// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel NOR flash. It takes one operation request at a time and turns it into the ordered bus cycles the device's command interface expects. Every command opens with a two-write unlock prologue to fixed offsets. The block runs each write and read cycle itself, with chip enable, write enable and output enable active-low and phase lengths counted in clock cycles.

Five operations are available. Identify reads the two ID bytes and compares them with expected values. Chip erase and sector erase clear memory. Byte program writes one byte. Full-device program works through the array one sector at a time: it erases the sector and then programs each of its bytes, taking the data from a local buffer port. Erase and program finish when the device's toggle bit stops changing between back-to-back reads. A bounded poll count turns a device that never settles into an error result.

Top module: `nor_cmd_seq`

## Requirements
- R1: In reset and while idle, fl_ce_n, fl_we_n and fl_oe_n are all 1 and busy and done are 0. fl_we_n and fl_oe_n are never low together.
- R2: Each bus cycle holds fl_ce_n low and drives fl_addr for TSU cycles, then pulses the strobe low for exactly TPW cycles, then holds for THD cycles. The strobe is fl_we_n for writes and fl_oe_n for reads. Address and write data stay stable for the whole low strobe. fl_dq_oe is high only during write cycles. fl_ce_n returns high for at least one cycle between bus cycles.
- R3: Identify (req_op=0) writes 0xAA@0x555, 0x55@0x2AA and 0x90@0x555. It then reads offset 0 into id_mfr and offset 1 into id_dev, and finally writes 0xF0@0. done follows 6×(TSU+TPW+THD+1) cycles after the accepting edge. ok is 1 only when both bytes equal EXP_MFR and EXP_DEV.
- R4: Chip erase (req_op=1) writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA and 0x10@555, then polls offset 0.
- R5: Sector erase (req_op=2) sends the same first five writes, then 0x30 to req_addr, then polls req_addr. Only the addressed sector is erased.
- R6: Byte program (req_op=3) writes AA@555, 55@2AA and A0@555, then req_data@req_addr, then polls req_addr.
- R7: Polling reads the operated address. The operation completes only when two consecutive reads agree on data bit 6, so done never comes while the device still reports busy.
- R8: If POLL_MAX poll reads pass without a settled toggle bit, the operation ends with err=1 and ok=0 after exactly POLL_MAX reads, and the bus returns idle.
- R9: Full-device program (req_op=4) erases each sector from address 0 upward. After each erase it programs every byte of that sector in ascending order with buf_data, where buf_addr presents the byte's address. It ends with ok=1 after the last byte.
- R10: A request raised while busy is ignored: it causes no bus command and no extra done.
- R11: busy is 1 from the cycle after a request is accepted until done. done is a one-cycle pulse in the cycle busy falls, and ok and err stay valid from then until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request, sampled while idle |
| req_op | input | 3 | 0 identify, 1 chip erase, 2 sector erase, 3 byte program, 4 full-device program |
| req_addr | input | AW | Target address for sector erase or byte program |
| req_data | input | 8 | Data byte for byte program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result: success / ID match |
| err | output | 1 | Poll timeout occurred |
| id_mfr | output | 8 | Manufacturer ID byte read by identify |
| id_dev | output | 8 | Device ID byte read by identify |
| buf_addr | output | AW | Address into the local data buffer (full-device mode) |
| buf_data | input | 8 | Buffer byte at buf_addr |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Identify contains no polling, so its done is due at a fixed 6×(TSU+TPW+THD+1) cycles after the accepting edge. The scoreboard records that edge's cycle number and compares it against the cycle in which done is seen. Erase and program latencies depend on how many reads the device model reports busy. For those operations the monitor checks at the done pulse, sampled on the falling clock edge, that the model has already finished. In the timeout case it checks that exactly POLL_MAX status reads occurred. Strobe widths and address stability are measured by the bus model on every cycle.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW       = 19,
  parameter int SECT_AW  = 16,
  parameter int TSU      = 2,
  parameter int TPW      = 3,
  parameter int THD      = 1,
  parameter int POLL_MAX = 200000,
  parameter logic [7:0] EXP_MFR = 8'h01,
  parameter logic [7:0] EXP_DEV = 8'hA4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          err,
  output logic [7:0]    id_mfr,
  output logic [7:0]    id_dev,
  output logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_data,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam logic [2:0] OP_ID   = 3'd0;
  localparam logic [2:0] OP_CHIP = 3'd1;
  localparam logic [2:0] OP_SECT = 3'd2;
  localparam logic [2:0] OP_PROG = 3'd3;
  localparam logic [2:0] OP_FULL = 3'd4;
  localparam int TMX = (TSU > TPW) ? ((TSU > THD) ? TSU : THD) : ((TPW > THD) ? TPW : THD);
  localparam int TW  = $clog2(TMX + 1);
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam logic [AW-1:0] UNL_A = AW'(11'h555);
  localparam logic [AW-1:0] UNL_B = AW'(11'h2AA);

  typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_PW, PH_HD} ph_t;

  ph_t           ph_q;
  logic [TW-1:0] tcnt_q;
  logic          brd_q;
  logic [AW-1:0] baddr_q;
  logic [7:0]    bdat_q;
  logic [7:0]    rd_q;

  logic          run_q, ers_q, poll_q, pfirst_q, t6_q;
  logic [2:0]    op_q, step_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, mfr_q, dev_q;
  logic [PCW-1:0] pcnt_q;
  logic          done_q, ok_q, err_q;

  logic [2:0]    kind;
  logic          s_rd, s_last;
  logic [AW-1:0] s_addr, poll_addr;
  logic [7:0]    s_dat, pdat;

  assign kind      = (op_q == OP_FULL) ? (ers_q ? OP_SECT : OP_PROG) : op_q;
  assign pdat      = (op_q == OP_FULL) ? buf_data : data_q;
  assign poll_addr = (kind == OP_CHIP) ? '0 : addr_q;

  always_comb begin
    s_rd   = 1'b0;
    s_addr = UNL_A;
    s_dat  = 8'hAA;
    s_last = 1'b0;
    case (step_q)
      3'd0: ;
      3'd1: begin s_addr = UNL_B; s_dat = 8'h55; end
      3'd2: begin
        case (kind)
          OP_ID:            s_dat = 8'h90;
          OP_CHIP, OP_SECT: s_dat = 8'h80;
          default:          s_dat = 8'hA0;
        endcase
      end
      3'd3: begin
        if (kind == OP_ID) begin
          s_rd = 1'b1; s_addr = '0;
        end else if (kind == OP_PROG) begin
          s_addr = addr_q; s_dat = pdat; s_last = 1'b1;
        end
      end
      3'd4: begin
        if (kind == OP_ID) begin
          s_rd = 1'b1; s_addr = AW'(1);
        end else begin
          s_addr = UNL_B; s_dat = 8'h55;
        end
      end
      3'd5: begin
        s_last = 1'b1;
        case (kind)
          OP_ID:   begin s_addr = '0; s_dat = 8'hF0; end
          OP_CHIP: s_dat = 8'h10;
          default: begin s_addr = addr_q; s_dat = 8'h30; end
        endcase
      end
      default: ;
    endcase
  end

  logic cyc_end, settled, ptimeout, unit_done, last_unit;
  assign cyc_end   = (ph_q == PH_HD) && (tcnt_q == '0);
  assign settled   = poll_q && !pfirst_q && (rd_q[6] == t6_q);
  assign ptimeout  = poll_q && !settled && (pcnt_q == PCW'(POLL_MAX - 1));
  assign unit_done = poll_q ? settled : (s_last && kind == OP_ID);
  assign last_unit = (op_q != OP_FULL) || (!ers_q && (&addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; tcnt_q <= '0; brd_q <= 1'b0; baddr_q <= '0; bdat_q <= '0; rd_q <= '0;
      run_q <= 1'b0; ers_q <= 1'b0; poll_q <= 1'b0; pfirst_q <= 1'b0; t6_q <= 1'b0;
      op_q <= '0; step_q <= '0; addr_q <= '0; data_q <= '0; mfr_q <= '0; dev_q <= '0;
      pcnt_q <= '0; done_q <= 1'b0; ok_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (req_valid) begin
          op_q   <= req_op;
          addr_q <= (req_op == OP_FULL) ? '0 : req_addr;
          data_q <= req_data;
          ers_q  <= 1'b1;
          step_q <= '0;
          poll_q <= 1'b0;
          ok_q   <= 1'b0;
          err_q  <= 1'b0;
          run_q  <= 1'b1;
        end
      end else begin
        case (ph_q)
          PH_IDLE: begin
            ph_q    <= PH_SU;
            tcnt_q  <= TW'(TSU - 1);
            brd_q   <= poll_q | s_rd;
            baddr_q <= poll_q ? poll_addr : s_addr;
            bdat_q  <= s_dat;
          end
          PH_SU: begin
            if (tcnt_q == '0) begin ph_q <= PH_PW; tcnt_q <= TW'(TPW - 1); end
            else tcnt_q <= tcnt_q - 1'b1;
          end
          PH_PW: begin
            if (tcnt_q == '0) begin
              ph_q <= PH_HD; tcnt_q <= TW'(THD - 1);
              if (brd_q) rd_q <= fl_dq_in;
            end else tcnt_q <= tcnt_q - 1'b1;
          end
          default: begin
            if (tcnt_q != '0) tcnt_q <= tcnt_q - 1'b1;
            else begin
              ph_q <= PH_IDLE;
              if (ptimeout) begin
                run_q <= 1'b0; done_q <= 1'b0 | 1'b1; err_q <= 1'b1; ok_q <= 1'b0; poll_q <= 1'b0;
              end else if (unit_done) begin
                poll_q <= 1'b0;
                step_q <= '0;
                if (last_unit) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
                  ok_q   <= (op_q == OP_ID) ? (mfr_q == EXP_MFR && dev_q == EXP_DEV) : 1'b1;
                end else if (ers_q) begin
                  ers_q <= 1'b0;
                end else begin
                  addr_q <= addr_q + 1'b1;
                  if (&addr_q[SECT_AW-1:0]) ers_q <= 1'b1;
                end
              end else if (poll_q) begin
                t6_q     <= rd_q[6];
                pfirst_q <= 1'b0;
                pcnt_q   <= pcnt_q + 1'b1;
              end else if (s_last) begin
                poll_q   <= 1'b1;
                pfirst_q <= 1'b1;
                pcnt_q   <= '0;
              end else begin
                step_q <= step_q + 1'b1;
                if (kind == OP_ID && step_q == 3'd3) mfr_q <= rd_q;
                if (kind == OP_ID && step_q == 3'd4) dev_q <= rd_q;
              end
            end
          end
        endcase
      end
    end
  end

  assign busy      = run_q;
  assign done      = done_q;
  assign ok        = ok_q;
  assign err       = err_q;
  assign id_mfr    = mfr_q;
  assign id_dev    = dev_q;
  assign buf_addr  = addr_q;
  assign fl_addr   = baddr_q;
  assign fl_dq_out = bdat_q;
  assign fl_ce_n   = (ph_q == PH_IDLE);
  assign fl_we_n   = !(ph_q == PH_PW && !brd_q);
  assign fl_oe_n   = !(ph_q == PH_PW && brd_q);
  assign fl_dq_oe  = (ph_q != PH_IDLE) && !brd_q;

  // R1
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  // R2
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  // R2
  dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  err_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !ok);
  // R10
  ignore_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(op_q));
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  localparam int AW = 11, SA = 8, TSU = 1, TPW = 2, THD = 1, PMAX = 12;
  localparam int P  = TSU + TPW + THD + 1;
  localparam int NB = 1 << AW;
  localparam int ER_READS = 3, PR_READS = 1;
  localparam logic [7:0] MFR = 8'h37, DEV = 8'hC2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic busy, done, ok, err, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [7:0] id_mfr, id_dev, buf_data, fl_dq_out, fl_dq_in;
  logic [AW-1:0] buf_addr, fl_addr;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] * 8'd7 ^ {5'd0, a[10:8]} ^ 8'h5C;
  endfunction
  assign buf_data = pat(buf_addr);

  nor_cmd_seq #(.AW(AW), .SECT_AW(SA), .TSU(TSU), .TPW(TPW), .THD(THD), .POLL_MAX(PMAX),
    .EXP_MFR(MFR), .EXP_DEV(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .ok(ok), .err(err), .id_mfr(id_mfr),
    .id_dev(id_dev), .buf_addr(buf_addr), .buf_data(buf_data), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int n_cmp = 0, n_bad = 0, cyc = 0, n_done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic cond, input int act, input int exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model
  logic [7:0] mem [NB];
  logic [7:0] m_mfr = MFR, m_dev = DEV;
  int st = 0, busy_left = 0, we_low = 0;
  int proto_bad = 0, tim_bad = 0, n_cmds = 0, n_stat = 0, n_writes = 0;
  logic id_mode = 1'b0, tog = 1'b0, stuck = 1'b0, chk_addr = 1'b0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] op_addr = '0, lat_a = '0, lat_ra = '0;
  logic [7:0] lat_d = '0;

  always_comb begin
    if (busy_left != 0)   fl_dq_in = {1'b0, tog, 6'b0};
    else if (id_mode)     fl_dq_in = (fl_addr == 0) ? m_mfr : (fl_addr == 1) ? m_dev : 8'h00;
    else                  fl_dq_in = mem[fl_addr];
  end

  task automatic dev_write(input logic [AW-1:0] a, input logic [7:0] d);
    if (busy_left != 0) begin proto_bad++; return; end
    if (id_mode) begin
      if (d == 8'hF0 && a == 0) begin id_mode = 1'b0; n_cmds++; end
      else proto_bad++;
      return;
    end
    case (st)
      0: if (a == 11'h555 && d == 8'hAA) st = 1; else proto_bad++;
      1: if (a == 11'h2AA && d == 8'h55) st = 2; else begin proto_bad++; st = 0; end
      2: begin
        st = 0;
        if (a != 11'h555) proto_bad++;
        else if (d == 8'h90) id_mode = 1'b1;
        else if (d == 8'hA0) st = 6;
        else if (d == 8'h80) st = 3;
        else proto_bad++;
      end
      3: if (a == 11'h555 && d == 8'hAA) st = 4; else begin proto_bad++; st = 0; end
      4: if (a == 11'h2AA && d == 8'h55) st = 5; else begin proto_bad++; st = 0; end
      5: begin
        st = 0;
        if (d == 8'h10 && a == 11'h555) begin
          for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
          busy_left = ER_READS; chk_addr = 1'b0; n_cmds++;
        end else if (d == 8'h30) begin
          for (int i = 0; i < (1 << SA); i++) mem[{a[AW-1:SA], SA'(i)}] = 8'hFF;
          busy_left = ER_READS; chk_addr = 1'b1; op_addr = a; n_cmds++;
        end else proto_bad++;
      end
      default: begin
        st = 0;
        mem[a] = mem[a] & d;
        busy_left = PR_READS; chk_addr = 1'b1; op_addr = a; n_cmds++;
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (prev_we) begin we_low = 0; lat_a = fl_addr; lat_d = fl_dq_out; end
      else if (fl_addr != lat_a || fl_dq_out != lat_d) tim_bad++;
      if (fl_ce_n || !fl_dq_oe) tim_bad++;
      we_low++;
    end else if (!prev_we) begin
      if (we_low != TPW) tim_bad++;
      n_writes++;
      dev_write(lat_a, lat_d);
    end
    if (!fl_oe_n) lat_ra = fl_addr;
    else if (!prev_oe && busy_left != 0) begin
      n_stat++;
      if (chk_addr && lat_ra != op_addr) proto_bad++;
      tog = ~tog;
      if (!stuck) busy_left--;
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  // scoreboard
  typedef struct packed {
    logic ok; logic err; logic chkid; logic [7:0] mfr; logic [7:0] dev; logic [15:0] lat; logic [31:0] t0;
  } exp_t;
  exp_t sb[$];
  string tq[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (sb.size() == 0) chk("R10 unexpected done", 1'b0, 1, 0);
      else begin
        exp_t e; string t;
        e = sb.pop_front(); t = tq.pop_front();
        chk({t, " ok"}, ok == e.ok, ok, e.ok);
        chk({t, " err"}, err == e.err, err, e.err);
        chk({t, " R11 busy low at done"}, !busy, busy, 0);
        if (e.chkid) begin
          chk({t, " mfr"}, id_mfr == e.mfr, id_mfr, e.mfr);
          chk({t, " dev"}, id_dev == e.dev, id_dev, e.dev);
        end
        if (e.lat != 0) chk({t, " latency"}, cyc - int'(e.t0) == int'(e.lat), cyc - int'(e.t0), e.lat);
        if (!stuck) chk({t, " R7 done after device ready"}, busy_left == 0, busy_left, 0);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input exp_t e, input string tag);
    int d0;
    @(negedge clk);
    while (busy) @(negedge clk);
    d0 = n_done;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    e.t0 = cyc;
    sb.push_back(e); tq.push_back(tag);
    chk({tag, " R11 busy after accept"}, busy, busy, 1);
    while (n_done == d0) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic eok, input logic eerr, input logic cid,
                              input logic [7:0] m, input logic [7:0] dv, input int lat);
    exp_t e;
    e.ok = eok; e.err = eerr; e.chkid = cid; e.mfr = m; e.dev = dv; e.lat = 16'(lat); e.t0 = '0;
    return e;
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog", 1'b0, cyc, 0);
    summary();
  end

  initial begin
    int c0, s0, bad;
    for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", fl_ce_n && fl_we_n && fl_oe_n, {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk("R1 reset busy/done", !busy && !done, {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle strobes", fl_ce_n && fl_we_n && fl_oe_n, {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);

    // R3 identify, match and two mismatches
    issue(3'd0, '0, '0, mk(1'b1, 1'b0, 1'b1, MFR, DEV, 6 * P), "R3 id match");
    m_dev = 8'h11;
    issue(3'd0, '0, '0, mk(1'b0, 1'b0, 1'b1, MFR, 8'h11, 6 * P), "R3 id dev mismatch");
    m_dev = DEV; m_mfr = 8'h38;
    issue(3'd0, '0, '0, mk(1'b0, 1'b0, 1'b1, 8'h38, DEV, 6 * P), "R3 id mfr mismatch");
    m_mfr = MFR;

    // R6 byte program
    issue(3'd3, 11'h123, 8'h5A, mk(1'b1, 1'b0, 1'b0, 0, 0, 0), "R6 program");
    chk("R6 byte stored", mem[11'h123] == 8'h5A, mem[11'h123], 8'h5A);

    // R5 sector erase of sector 1 only
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    issue(3'd2, 11'h1C4, '0, mk(1'b1, 1'b0, 1'b0, 0, 0, 0), "R5 sector erase");
    bad = 0;
    for (int i = 0; i < NB; i++)
      if (mem[i] != (((i >> SA) == 1) ? 8'hFF : 8'h00)) bad++;
    chk("R5 only sector 1 erased", bad == 0, bad, 0);

    // R4 chip erase
    issue(3'd1, '0, '0, mk(1'b1, 1'b0, 1'b0, 0, 0, 0), "R4 chip erase");
    bad = 0;
    for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) bad++;
    chk("R4 all erased", bad == 0, bad, 0);

    // R8 timeout
    stuck = 1'b1; s0 = n_stat;
    issue(3'd3, 11'h040, 8'h00, mk(1'b0, 1'b1, 1'b0, 0, 0, 0), "R8 timeout");
    chk("R8 poll read count", n_stat - s0 == PMAX, n_stat - s0, PMAX);
    @(negedge clk);
    chk("R8 bus idle after timeout", fl_ce_n && !busy, {fl_ce_n, busy}, 2'b10);
    stuck = 1'b0; busy_left = 0;

    // R10 request during busy ignored
    mem[11'h700] = 8'h00;
    c0 = n_cmds;
    fork
      issue(3'd3, 11'h050, 8'h3C, mk(1'b1, 1'b0, 1'b0, 0, 0, 0), "R10 program");
      begin
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (60) @(negedge clk);
    chk("R10 one command only", n_cmds - c0 == 1, n_cmds - c0, 1);
    chk("R10 no erase happened", mem[11'h700] == 8'h00, mem[11'h700], 0);
    chk("R10 byte programmed", mem[11'h050] == 8'h3C, mem[11'h050], 8'h3C);

    // R9 full-device program
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    c0 = n_cmds;
    issue(3'd4, '0, '0, mk(1'b1, 1'b0, 1'b0, 0, 0, 0), "R9 full program");
    bad = 0;
    for (int i = 0; i < NB; i++) if (mem[i] != pat(AW'(i))) bad++;
    chk("R9 array equals buffer", bad == 0, bad, 0);
    chk("R9 command count", n_cmds - c0 == NB + (NB >> SA), n_cmds - c0, NB + (NB >> SA));

    repeat (10) @(negedge clk);
    chk("R2 bus timing", tim_bad == 0 && n_writes > 0, tim_bad, 0);
    chk("R3 R4 R5 R6 R7 command protocol", proto_bad == 0, proto_bad, 0);
    chk("R10 scoreboard drained", sb.size() == 0, sb.size(), 0);
    summary();
  end
endmodule